// File: doc/BRIEF.md
# Ethernet / IPv6 Streaming Header Parser

This block sits at the front of a packet pipeline. It watches a 64-bit byte stream with a valid/ready handshake, an end-of-packet marker and a byte-enable mask, and it pulls out the Ethernet header. When the EtherType announces IPv6, it also pulls out the fixed 40-byte IPv6 header. The parser then looks at the IPv6 Next Header field to see whether a routing extension header comes next. Only two decisions are made: EtherType against the IPv6 code, and Next Header against the routing-extension code. Any other value ends parsing, and the packet goes straight on to ingress.

Bytes after the headers are drained and discarded. Once the last beat of a packet has been taken, the block presents every parsed field together with one valid flag per header and a truncation flag. This result is offered on an output valid/ready pair, and the accepting cycle is the handoff to the ingress stage. Input is stalled until that handoff occurs, so each packet produces exactly one result.

Top module: `hdrParse`

## Requirements
- R1: Byte 0 of a beat is on sTdata[63:56] and byte 7 is on sTdata[7:0]. sTkeep[7] enables byte 0 and sTkeep[0] enables byte 7, and set bits are contiguous from bit 7 downward. Packet bytes are numbered in arrival order across beats, whatever the number of bytes per beat.
- R2: Packet bytes 0-5 form ethDst, bytes 6-11 form ethSrc and bytes 12-13 form etherType, with the lower-numbered byte most significant. ethValid is 1 when at least 14 bytes arrived.
- R3: An etherType other than 0x86DD ends parsing. In that case ipv6Valid and extNext are 0 and truncErr is 0, provided ethValid is 1.
- R4: With etherType 0x86DD, bytes 14-53 supply the IPv6 fields, numbering bits from the MSB of byte 14: ipVersion at bits 0-3, ipTrafficClass at 4-11, ipFlowLabel at 12-31, ipPayloadLen at 32-47, ipNextHdr at 48-55, ipHopLimit at 56-63, ipSrcAddr at 64-191 and ipDstAddr at 192-319. ipv6Valid is 1 when the packet has at least 54 bytes.
- R5: extNext is 1 exactly when ipv6Valid is 1 and ipNextHdr equals 0x2B.
- R6: truncErr is 1 when the packet ends before byte 14, or when etherType is 0x86DD and the packet ends before byte 54. The header that was not completed keeps its valid flag at 0.
- R7: outValid rises in the cycle after the beat carrying sTlast is accepted. It stays high, with every output stable, until a cycle with outReady high. sTready is 0 while outValid is 1.
- R8: All fields and flags are cleared when the first beat of a packet is taken. Header bytes a short packet did not supply read as 0.
- R9: Bytes after byte 53 do not change any reported field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sTvalid | input | 1 | Input beat valid |
| sTready | output | 1 | Input beat ready |
| sTdata | input | 64 | Input bytes, byte 0 in the top lane |
| sTkeep | input | 8 | Byte enables, bit 7 for byte 0 |
| sTlast | input | 1 | Last beat of the packet |
| outValid | output | 1 | Parsed result offered |
| outReady | input | 1 | Ingress stage accepts the result |
| ethValid | output | 1 | Ethernet header complete |
| ipv6Valid | output | 1 | IPv6 fixed header complete |
| extNext | output | 1 | Routing extension header follows |
| truncErr | output | 1 | Packet ended inside a header |
| ethDst | output | 48 | Destination MAC address |
| ethSrc | output | 48 | Source MAC address |
| etherType | output | 16 | EtherType |
| ipVersion | output | 4 | IPv6 version |
| ipTrafficClass | output | 8 | IPv6 traffic class |
| ipFlowLabel | output | 20 | IPv6 flow label |
| ipPayloadLen | output | 16 | IPv6 payload length |
| ipNextHdr | output | 8 | IPv6 next header |
| ipHopLimit | output | 8 | IPv6 hop limit |
| ipSrcAddr | output | 128 | IPv6 source address |
| ipDstAddr | output | 128 | IPv6 destination address |

## Verification
In a single beat, the EtherType decision can coincide with the end of the packet. The bench provokes this with a 16-byte packet sent as two full beats and carrying EtherType 0x86DD. The Ethernet header completes in the same beat that carries sTlast, so the move to IPv6 and the truncation verdict are taken on one edge. The result is judged as ethValid high, ipv6Valid low and truncErr high. A 54-byte packet in 6-byte beats puts the Next Header test and the last beat together in the same way, and it must report both ipv6Valid and extNext without any truncation.

// File: rtl/hdrParsePkg.sv
package hdrParsePkg;
  localparam int ETH_BYTES = 14;
  localparam int IP6_BYTES = 40;
  localparam int HDR_BYTES = ETH_BYTES + IP6_BYTES;
  localparam logic [15:0] ETYPE_IPV6 = 16'h86DD;
  localparam logic [7:0]  NH_ROUTING = 8'h2B;

  typedef enum logic [1:0] {ST_ETH, ST_IP6, ST_SKIP, ST_OUT} parseState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic take;   // beat accepted this cycle
    logic clr;    // beat is the first of a packet
  } dpStrobe_t;
endpackage

// File: rtl/hdrParseData.sv
module hdrParseData
  import hdrParsePkg::*;
#(
  parameter int DATA_W = 64,
  parameter int CNT_W  = 8,
  localparam int KEEP_W = DATA_W / 8,
  localparam int NB_W   = $clog2(KEEP_W + 1),
  localparam int HDR_W  = HDR_BYTES * 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] tdata,
  input  logic [KEEP_W-1:0] tkeep,
  output logic [CNT_W-1:0]  cntNext,
  output logic [15:0]       nxtEtherType,
  output logic [7:0]        nxtNextHdr,
  output logic [HDR_W-1:0]  hdrFlat
);
  logic [CNT_W-1:0] byteCnt;
  logic [CNT_W-1:0] base;
  logic [CNT_W:0]   sum;
  logic [NB_W-1:0]  nBytes;
  logic [7:0]       hb     [HDR_BYTES];
  logic [7:0]       hbNext [HDR_BYTES];

  always_comb begin
    nBytes  = NB_W'($countones(tkeep));
    base    = strobe.clr ? '0 : byteCnt;
    sum     = {1'b0, base} + (CNT_W+1)'(nBytes);
    cntNext = sum[CNT_W] ? '1 : sum[CNT_W-1:0];
  end

  // each header byte picks the lane whose packet position matches it
  for (genvar i = 0; i < HDR_BYTES; i++) begin : gByte
    always_comb begin
      hbNext[i] = strobe.clr ? 8'h00 : hb[i];
      for (int j = 0; j < KEEP_W; j++) begin
        if (strobe.take && tkeep[KEEP_W-1-j] && (int'(base) + j == i))
          hbNext[i] = tdata[DATA_W-1-8*j -: 8];
      end
    end
    assign hdrFlat[HDR_W-1-8*i -: 8] = hb[i];
  end

  assign nxtEtherType = {hbNext[12], hbNext[13]};
  assign nxtNextHdr   = hbNext[ETH_BYTES + 6];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteCnt <= '0;
      for (int k = 0; k < HDR_BYTES; k++) hb[k] <= 8'h00;
    end else begin
      if (strobe.take) byteCnt <= cntNext;
      for (int k = 0; k < HDR_BYTES; k++) hb[k] <= hbNext[k];
    end
  end
endmodule

// File: rtl/hdrParseCtrl.sv
module hdrParseCtrl
  import hdrParsePkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tvalid,
  input  logic             tlast,
  input  logic             outReady,
  input  logic [CNT_W-1:0] cntNext,
  input  logic [15:0]      nxtEtherType,
  input  logic [7:0]       nxtNextHdr,
  output logic             tready,
  output dpStrobe_t        strobe,
  output logic             outValid,
  output logic             ethValid,
  output logic             ipv6Valid,
  output logic             extNext,
  output logic             truncErr
);
  parseState_t state, stNext;
  logic atStart;
  logic take, ethDone, ipDone, isIp6;
  logic eN, iN, xN, tN;

  always_comb begin
    tready      = (state != ST_OUT);
    outValid    = (state == ST_OUT);
    take        = tvalid && tready;
    strobe.take = take;
    strobe.clr  = take && atStart;
    ethDone     = cntNext >= CNT_W'(ETH_BYTES);
    ipDone      = cntNext >= CNT_W'(HDR_BYTES);
    isIp6       = (nxtEtherType == ETYPE_IPV6);

    stNext = state;
    eN = strobe.clr ? 1'b0 : ethValid;
    iN = strobe.clr ? 1'b0 : ipv6Valid;
    xN = strobe.clr ? 1'b0 : extNext;
    tN = strobe.clr ? 1'b0 : truncErr;

    case (state)
      ST_ETH: if (take) begin
        if (ethDone) begin
          eN = 1'b1;
          if (isIp6) begin
            if (ipDone) begin
              iN = 1'b1;
              xN = (nxtNextHdr == NH_ROUTING);
              stNext = ST_SKIP;
            end else stNext = ST_IP6;
          end else stNext = ST_SKIP;
        end
        if (tlast) begin
          stNext = ST_OUT;
          if (!ethDone || (isIp6 && !ipDone)) tN = 1'b1;
        end
      end
      ST_IP6: if (take) begin
        if (ipDone) begin
          iN = 1'b1;
          xN = (nxtNextHdr == NH_ROUTING);
          stNext = ST_SKIP;
        end
        if (tlast) begin
          stNext = ST_OUT;
          if (!ipDone) tN = 1'b1;
        end
      end
      ST_SKIP: if (take && tlast) stNext = ST_OUT;
      ST_OUT:  if (outReady) stNext = ST_ETH;
      default: stNext = ST_ETH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_ETH;
      atStart   <= 1'b1;
      ethValid  <= 1'b0;
      ipv6Valid <= 1'b0;
      extNext   <= 1'b0;
      truncErr  <= 1'b0;
    end else begin
      state     <= stNext;
      if (take) atStart <= tlast;
      ethValid  <= eN;
      ipv6Valid <= iN;
      extNext   <= xN;
      truncErr  <= tN;
    end
  end
endmodule

// File: rtl/hdrParse.sv
module hdrParse
  import hdrParsePkg::*;
#(
  parameter int DATA_W = 64,
  parameter int CNT_W  = 8,
  localparam int KEEP_W = DATA_W / 8,
  localparam int HDR_W  = HDR_BYTES * 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sTvalid,
  output logic              sTready,
  input  logic [DATA_W-1:0] sTdata,
  input  logic [KEEP_W-1:0] sTkeep,
  input  logic              sTlast,
  output logic              outValid,
  input  logic              outReady,
  output logic              ethValid,
  output logic              ipv6Valid,
  output logic              extNext,
  output logic              truncErr,
  output logic [47:0]       ethDst,
  output logic [47:0]       ethSrc,
  output logic [15:0]       etherType,
  output logic [3:0]        ipVersion,
  output logic [7:0]        ipTrafficClass,
  output logic [19:0]       ipFlowLabel,
  output logic [15:0]       ipPayloadLen,
  output logic [7:0]        ipNextHdr,
  output logic [7:0]        ipHopLimit,
  output logic [127:0]      ipSrcAddr,
  output logic [127:0]      ipDstAddr
);
  dpStrobe_t        strobe;
  logic [CNT_W-1:0] cntNext;
  logic [15:0]      nxtEtherType;
  logic [7:0]       nxtNextHdr;
  logic [HDR_W-1:0] hdrFlat;

  hdrParseCtrl #(.CNT_W(CNT_W)) ctrl (
    .clk(clk), .rstN(rstN), .tvalid(sTvalid), .tlast(sTlast),
    .outReady(outReady), .cntNext(cntNext), .nxtEtherType(nxtEtherType),
    .nxtNextHdr(nxtNextHdr), .tready(sTready), .strobe(strobe),
    .outValid(outValid), .ethValid(ethValid), .ipv6Valid(ipv6Valid),
    .extNext(extNext), .truncErr(truncErr)
  );

  hdrParseData #(.DATA_W(DATA_W), .CNT_W(CNT_W)) data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .tdata(sTdata), .tkeep(sTkeep),
    .cntNext(cntNext), .nxtEtherType(nxtEtherType), .nxtNextHdr(nxtNextHdr),
    .hdrFlat(hdrFlat)
  );

  assign ethDst         = hdrFlat[HDR_W-1   -: 48];
  assign ethSrc         = hdrFlat[HDR_W-49  -: 48];
  assign etherType      = hdrFlat[HDR_W-97  -: 16];
  assign ipVersion      = hdrFlat[HDR_W-113 -: 4];
  assign ipTrafficClass = hdrFlat[HDR_W-117 -: 8];
  assign ipFlowLabel    = hdrFlat[HDR_W-125 -: 20];
  assign ipPayloadLen   = hdrFlat[HDR_W-145 -: 16];
  assign ipNextHdr      = hdrFlat[HDR_W-161 -: 8];
  assign ipHopLimit     = hdrFlat[HDR_W-169 -: 8];
  assign ipSrcAddr      = hdrFlat[HDR_W-177 -: 128];
  assign ipDstAddr      = hdrFlat[HDR_W-305 -: 128];
endmodule

// File: rtl/hdrParseChk.sv
module hdrParseChk (
  input logic         clk,
  input logic         rstN,
  input logic         sTready,
  input logic         outValid,
  input logic         outReady,
  input logic         ethValid,
  input logic         ipv6Valid,
  input logic         extNext,
  input logic         truncErr,
  input logic [15:0]  etherType,
  input logic [7:0]   ipNextHdr,
  input logic [47:0]  ethDst,
  input logic [127:0] ipDstAddr
);
  assert_ready_blocked_R7: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !sTready);

  assert_hold_result_R7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(ethDst) &&
                                 $stable(ipDstAddr) && $stable(truncErr)));

  assert_ipv6_gate_R3: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && ipv6Valid) |-> (ethValid && etherType == 16'h86DD));

  assert_ext_gate_R5: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && extNext) |-> (ipv6Valid && ipNextHdr == 8'h2B));

  assert_short_eth_R6: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !ethValid) |-> (truncErr && !ipv6Valid));

  assert_trunc_excl_R6: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && truncErr) |-> (!ipv6Valid && !extNext));
endmodule

bind hdrParse hdrParseChk chk (
  .clk(clk), .rstN(rstN), .sTready(sTready), .outValid(outValid),
  .outReady(outReady), .ethValid(ethValid), .ipv6Valid(ipv6Valid),
  .extNext(extNext), .truncErr(truncErr), .etherType(etherType),
  .ipNextHdr(ipNextHdr), .ethDst(ethDst), .ipDstAddr(ipDstAddr)
);

// File: tb/hdrParse_test.sv
`timescale 1ns/1ps
module hdrParse_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sTvalid = 1'b0, sTlast = 1'b0, outReady = 1'b0;
  logic [63:0] sTdata = '0;
  logic [7:0]  sTkeep = '0;
  logic sTready, outValid, ethValid, ipv6Valid, extNext, truncErr;
  logic [47:0] ethDst, ethSrc;
  logic [15:0] etherType, ipPayloadLen;
  logic [3:0]  ipVersion;
  logic [7:0]  ipTrafficClass, ipNextHdr, ipHopLimit;
  logic [19:0] ipFlowLabel;
  logic [127:0] ipSrcAddr, ipDstAddr;

  int compared = 0;
  int mismatched = 0;
  logic [7:0] pkt [0:127];
  int pktLen = 0;

  always #2.5 clk = ~clk;

  hdrParse uut (
    .clk(clk), .rstN(rstN), .sTvalid(sTvalid), .sTready(sTready),
    .sTdata(sTdata), .sTkeep(sTkeep), .sTlast(sTlast), .outValid(outValid),
    .outReady(outReady), .ethValid(ethValid), .ipv6Valid(ipv6Valid),
    .extNext(extNext), .truncErr(truncErr), .ethDst(ethDst), .ethSrc(ethSrc),
    .etherType(etherType), .ipVersion(ipVersion), .ipTrafficClass(ipTrafficClass),
    .ipFlowLabel(ipFlowLabel), .ipPayloadLen(ipPayloadLen), .ipNextHdr(ipNextHdr),
    .ipHopLimit(ipHopLimit), .ipSrcAddr(ipSrcAddr), .ipDstAddr(ipDstAddr)
  );

  task automatic chk(string what, logic [127:0] act, logic [127:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic buildPkt(int len, logic [15:0] etype, logic [7:0] nh, int seed);
    for (int i = 0; i < 128; i++) pkt[i] = 8'(i * 37 + seed * 11 + 5);
    pkt[12] = etype[15:8];
    pkt[13] = etype[7:0];
    pkt[20] = nh;
    pktLen = len;
  endtask

  // R1: byte 0 in the top lane, keep bits set from bit 7 downward
  task automatic sendPkt(int perBeat);
    int pos = 0;
    while (pos < pktLen) begin
      int n;
      @(negedge clk);
      n = (pktLen - pos < perBeat) ? pktLen - pos : perBeat;
      sTdata = '0;
      sTkeep = '0;
      for (int j = 0; j < n; j++) begin
        sTdata[63-8*j -: 8] = pkt[pos+j];
        sTkeep[7-j] = 1'b1;
      end
      sTlast = (pos + n >= pktLen);
      sTvalid = 1'b1;
      @(posedge clk);
      pos += n;
    end
    @(negedge clk);
    sTvalid = 1'b0;
    sTlast = 1'b0;
  endtask

  // compares the result against values derived from the requirements
  task automatic checkOut(string scen);
    logic [431:0] ef;
    logic eV, isIp, iV, xV, tV;
    for (int k = 0; k < 54; k++) ef[431-8*k -: 8] = (k < pktLen) ? pkt[k] : 8'h00;
    eV   = (pktLen >= 14);
    isIp = eV && ({pkt[12], pkt[13]} == 16'h86DD);
    iV   = isIp && (pktLen >= 54);
    xV   = iV && (pkt[20] == 8'h2B);
    tV   = !eV || (isIp && !iV);
    chk({scen, " R7 outValid"}, 128'(outValid), 128'(1));
    chk({scen, " R7 sTready"}, 128'(sTready), 128'(0));
    chk({scen, " R2 ethValid"}, 128'(ethValid), 128'(eV));
    chk({scen, " R3 ipv6Valid"}, 128'(ipv6Valid), 128'(iV));
    chk({scen, " R5 extNext"}, 128'(extNext), 128'(xV));
    chk({scen, " R6 truncErr"}, 128'(truncErr), 128'(tV));
    chk({scen, " R2 ethDst"}, 128'(ethDst), 128'(ef[431 -: 48]));
    chk({scen, " R2 ethSrc"}, 128'(ethSrc), 128'(ef[383 -: 48]));
    chk({scen, " R2 etherType"}, 128'(etherType), 128'(ef[335 -: 16]));
    chk({scen, " R4 ipVersion"}, 128'(ipVersion), 128'(ef[319 -: 4]));
    chk({scen, " R4 ipTrafficClass"}, 128'(ipTrafficClass), 128'(ef[315 -: 8]));
    chk({scen, " R4 ipFlowLabel"}, 128'(ipFlowLabel), 128'(ef[307 -: 20]));
    chk({scen, " R4 ipPayloadLen"}, 128'(ipPayloadLen), 128'(ef[287 -: 16]));
    chk({scen, " R4 ipNextHdr"}, 128'(ipNextHdr), 128'(ef[271 -: 8]));
    chk({scen, " R4 ipHopLimit"}, 128'(ipHopLimit), 128'(ef[263 -: 8]));
    chk({scen, " R4 ipSrcAddr"}, ipSrcAddr, ef[255 -: 128]);
    chk({scen, " R4 ipDstAddr"}, ipDstAddr, ef[127 -: 128]);
  endtask

  // R7: result held while outReady is low, released on acceptance
  task automatic acceptOut(string scen, int hold);
    logic [47:0] d0 = ethDst;
    logic [127:0] a0 = ipDstAddr;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk({scen, " R7 held valid"}, 128'(outValid), 128'(1));
      chk({scen, " R7 held ready low"}, 128'(sTready), 128'(0));
      chk({scen, " R7 held ethDst"}, 128'(ethDst), 128'(d0));
      chk({scen, " R7 held ipDstAddr"}, ipDstAddr, a0);
    end
    outReady = 1'b1;
    @(negedge clk);
    outReady = 1'b0;
    chk({scen, " R7 released valid"}, 128'(outValid), 128'(0));
    chk({scen, " R7 released ready"}, 128'(sTready), 128'(1));
  endtask

  task automatic runPkt(string scen, int len, logic [15:0] et, logic [7:0] nh,
                        int seed, int perBeat, int hold);
    buildPkt(len, et, nh, seed);
    sendPkt(perBeat);
    checkOut(scen);
    acceptOut(scen, hold);
  endtask

  task automatic testReset;
    chk("reset R7 outValid", 128'(outValid), 128'(0));
    chk("reset R7 sTready", 128'(sTready), 128'(1));
  endtask

  // R1 R2 R4 R5 R9: long IPv6 packet with routing extension, full beats
  task automatic testExtFull;
    runPkt("extFull R9", 70, 16'h86DD, 8'h2B, 1, 8, 3);
  endtask

  // R1: fields straddle beats of 3 bytes
  task automatic testStraddle;
    runPkt("straddle R1", 64, 16'h86DD, 8'h11, 2, 3, 0);
  endtask

  // R3: non-IPv6 EtherType ends parsing without error
  task automatic testOtherType;
    runPkt("ipv4 R3", 60, 16'h0800, 8'h2B, 3, 8, 1);
  endtask

  // R6 R8: short packet after a long one, stale bytes must read 0
  task automatic testShort;
    runPkt("long R8", 70, 16'h86DD, 8'h2B, 4, 8, 0);
    runPkt("short R8", 10, 16'h86DD, 8'h2B, 5, 8, 0);
  endtask

  // R2 R6: Ethernet length boundary
  task automatic testEthEdge;
    runPkt("eth13 R6", 13, 16'h0800, 8'h00, 6, 5, 0);
    runPkt("eth14 R2", 14, 16'h0800, 8'h00, 7, 5, 0);
  endtask

  // R6: EtherType decision and end of packet in the same beat
  task automatic testSameBeat;
    runPkt("sameBeat R6", 16, 16'h86DD, 8'h2B, 8, 8, 0);
  endtask

  // R4 R5: packet ends exactly at the IPv6 header end
  task automatic testExact;
    runPkt("exact54 R5", 54, 16'h86DD, 8'h2B, 9, 6, 0);
    runPkt("exact53 R6", 53, 16'h86DD, 8'h2B, 10, 7, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL R7 watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testExtFull();
    testStraddle();
    testOtherType();
    testShort();
    testEthEdge();
    testSameBeat();
    testExact();
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule